// File: doc/BRIEF.md
# Pausable-Clock Initiator Handshake Port

This block models the initiating side of a four-phase handshake port. The port sits between a locally clocked island and a partner module. When the island raises its port enable, the port requests the partner. It asks the local clock generator to pause only after the partner has answered. Once the pause is granted, it tells the island that the transfer is done. It then returns every handshake line to zero in a fixed order.

The transfer-done flag stays high until the island drops its enable, rather than pulsing for one clock. The island can therefore sample it at leisure. The port is written as a synchronous state machine on a fast reference clock and makes at most one output transition per clock. The three level inputs pass through a configurable synchronizer chain. Input levels that the current phase does not allow latch a sticky protocol-error flag, which only reset clears.

Top module: `pcport_initiator`

## Requirements
- R1: While `rst_n` is low, the next clock edge drives `req_o`, `ri_o`, `ta_o` and `err_o` low and puts the port in its idle phase.
- R2: In idle, a high `pen_i` raises `req_o` and nothing else. While `ack_i` stays low, `ri_o` and `ta_o` stay low however long `pen_i` is held.
- R3: `ri_o` rises only after `ack_i` has been seen high while `req_o` is high.
- R4: After `ai_i` is seen high while `ri_o` is high, `ta_o` rises, and `req_o` falls on the clock edge immediately after.
- R5: After `req_o` falls, `ri_o` falls only after `ack_i` has been seen low. The return order of the handshake lines is: request low, acknowledge low, pause request low, pause grant low.
- R6: `ta_o` stays high for as long as `pen_i` stays high, for any number of cycles. It falls only after `pen_i` is seen low, once `ai_i` has fallen. The port is then idle again.
- R7: On any clock edge, at most one of `req_o`, `ri_o`, `ta_o` changes.
- R8: `err_o` rises when a sampled input level is not allowed in the current phase. The allowed levels by phase are: idle, ack=0 and ai=0. Requesting, pen=1 and ai=0. Paused, pen=1 and ack=1. Granted, all three 1. Dropping, pen=1 and ai=1. Releasing, pen=1 and ack=0. Holding, ack=0 and ai=0. Any level may be seen on the input the phase waits for. Once high, `err_o` stays high until reset. An illegal input does not move the outputs.
- R9: An input change reaches the outputs on the SYNC_STAGES+1-th rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pen_i | input | 1 | Port enable from the island (level) |
| ack_i | input | 1 | Acknowledge from the partner |
| ai_i | input | 1 | Pause granted by the local clock generator |
| req_o | output | 1 | Request to the partner |
| ri_o | output | 1 | Clock-pause request to the clock generator |
| ta_o | output | 1 | Transfer-done flag to the island |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the port with the default SYNC_STAGES of 2. This puts the three-edge input-to-output latency of R9 within reach of a direct cycle count. With a two-flop chain, a single-cycle illegal pulse on an input still reaches the legality check. The partner and clock-generator models answer after random delays of one to five cycles. The island holds its enable for ten to forty cycles after the grant drops. Together these exercise many interleavings of the ordered return-to-zero phase and long holds of the transfer-done flag.

// File: rtl/pcport_pkg.sv
// Shared types and decode helpers for the pausable-clock initiator port.
// Assumes: inputs are already synchronized when these helpers see them.
package pcport_pkg;

    // Handshake phases; each phase fixes one output pattern.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,  // all outputs low, waiting for enable
        PH_REQ     = 3'd1,  // request out, waiting for partner acknowledge
        PH_PAUSE   = 3'd2,  // pause requested, waiting for grant
        PH_GRANT   = 3'd3,  // transfer done flagged, request still high
        PH_DROP    = 3'd4,  // request low, waiting for acknowledge low
        PH_RELEASE = 3'd5,  // pause request low, waiting for grant low
        PH_HOLD    = 3'd6   // done flag held, waiting for enable low
    } phase_t;

    // Sampled input levels.
    typedef struct packed {
        logic pen;
        logic ack;
        logic ai;
    } sense_t;

    // Driven output levels.
    typedef struct packed {
        logic req;
        logic ri;
        logic ta;
    } drive_t;

    localparam int SENSE_W = $bits(sense_t);

    // Output pattern belonging to each phase.
    function automatic drive_t drive_of(input phase_t ph);
        drive_t d;
        d = '0;
        case (ph)
            PH_IDLE:    d = '{req: 1'b0, ri: 1'b0, ta: 1'b0};
            PH_REQ:     d = '{req: 1'b1, ri: 1'b0, ta: 1'b0};
            PH_PAUSE:   d = '{req: 1'b1, ri: 1'b1, ta: 1'b0};
            PH_GRANT:   d = '{req: 1'b1, ri: 1'b1, ta: 1'b1};
            PH_DROP:    d = '{req: 1'b0, ri: 1'b1, ta: 1'b1};
            PH_RELEASE: d = '{req: 1'b0, ri: 1'b0, ta: 1'b1};
            PH_HOLD:    d = '{req: 1'b0, ri: 1'b0, ta: 1'b1};
            default:    d = '0;
        endcase
        return d;
    endfunction

    // True when the sampled levels are allowed in the given phase.
    function automatic logic levels_ok(input phase_t ph, input sense_t s);
        logic ok;
        case (ph)
            PH_IDLE:    ok = !s.ack && !s.ai;
            PH_REQ:     ok = s.pen && !s.ai;
            PH_PAUSE:   ok = s.pen && s.ack;
            PH_GRANT:   ok = s.pen && s.ack && s.ai;
            PH_DROP:    ok = s.pen && s.ai;
            PH_RELEASE: ok = s.pen && !s.ack;
            PH_HOLD:    ok = !s.ack && !s.ai;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pcport_sync.sv
// Multi-flop level synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is an independent level; STAGES = 0 gives a direct path.
module pcport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];

            // Shift the levels through the chain, clearing on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign dout = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pcport_fsm.sv
// Phase sequencer of the initiator port: one output transition per step.
// Assumes: synchronized inputs; illegal levels are flagged elsewhere and
// simply do not advance the phase here.
module pcport_fsm
    import pcport_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_t sense,
    output phase_t phase
);

    phase_t phase_q, phase_d;

    // Choose the next phase from the current phase and sampled levels.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (sense.pen && !sense.ack && !sense.ai) phase_d = PH_REQ;
            PH_REQ:     if (sense.pen && sense.ack && !sense.ai)  phase_d = PH_PAUSE;
            PH_PAUSE:   if (sense.pen && sense.ack && sense.ai)   phase_d = PH_GRANT;
            PH_GRANT:   phase_d = PH_DROP;
            PH_DROP:    if (sense.pen && !sense.ack && sense.ai)  phase_d = PH_RELEASE;
            PH_RELEASE: if (sense.pen && !sense.ack && !sense.ai) phase_d = PH_HOLD;
            PH_HOLD:    if (!sense.pen && !sense.ack && !sense.ai) phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
        endcase
    end

    // Hold the current phase; reset returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

endmodule

// File: rtl/pcport_guard.sv
// Protocol watchdog: latches a sticky error on input levels the phase forbids.
// Assumes: synchronized inputs; only reset clears the flag.
module pcport_guard
    import pcport_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  sense_t sense,
    output logic   err
);

    logic err_q;

    // Set on any forbidden level, keep until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        err_q <= 1'b0;
        else if (!levels_ok(phase, sense)) err_q <= 1'b1;
    end

    assign err = err_q;

endmodule

// File: rtl/pcport_initiator.sv
// Top of the pausable-clock initiator port: synchronizes the three level
// inputs, sequences the handshake phases and flags protocol violations.
// Assumes: reference clock well above the handshake rate; synchronous
// active-low reset.
module pcport_initiator
    import pcport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pen_i,
    input  logic ack_i,
    input  logic ai_i,
    output logic req_o,
    output logic ri_o,
    output logic ta_o,
    output logic err_o
);

    sense_t raw_in, sensed;
    phase_t phase;
    drive_t drv;
    logic   pen_s, ack_s, ai_s;

    assign raw_in = '{pen: pen_i, ack: ack_i, ai: ai_i};

    pcport_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sensed)
    );

    assign pen_s = sensed.pen;
    assign ack_s = sensed.ack;
    assign ai_s  = sensed.ai;

    pcport_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sense (sensed),
        .phase (phase)
    );

    pcport_guard u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .sense (sensed),
        .err   (err_o)
    );

    assign drv   = drive_of(phase);
    assign req_o = drv.req;
    assign ri_o  = drv.ri;
    assign ta_o  = drv.ta;

endmodule

// File: rtl/pcport_initiator_chk.sv
// Protocol checker for the initiator port, bound onto its top module.
// Assumes: sees the synchronized inputs through the bind connection.
module pcport_initiator_chk (
    input logic clk,
    input logic rst_n,
    input logic pen_s,
    input logic ack_s,
    input logic ai_s,
    input logic req_o,
    input logic ri_o,
    input logic ta_o,
    input logic err_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!req_o && !ri_o && !ta_o && !err_o));                       // R1

    AST_REQ_RISES_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (!ri_o && !ta_o && $past(pen_s)));                     // R2

    AST_PAUSE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri_o) |-> (req_o && $past(ack_s)));                               // R3

    AST_REQ_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> (ta_o && $past(ta_o)));                                // R4

    AST_DONE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ta_o) |-> $past(ai_s));                                           // R4

    AST_PAUSE_DROP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ri_o) |-> (!req_o && $past(!ack_s)));                             // R5

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_o && pen_s) |=> ta_o);                                              // R6

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_o, ri_o, ta_o} ^ $past({req_o, ri_o, ta_o})) <= 1);     // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);                                                       // R8

endmodule

bind pcport_initiator pcport_initiator_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pen_s (pen_s),
    .ack_s (ack_s),
    .ai_s  (ai_s),
    .req_o (req_o),
    .ri_o  (ri_o),
    .ta_o  (ta_o),
    .err_o (err_o)
);

// File: tb/pcport_initiator_tb.sv
// Scoreboard bench: the island driver queues the expected output events,
// a monitor pops them as outputs change; partner and clock-generator models
// answer with random delays.
module pcport_initiator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    localparam int EV_REQ_UP = 0;
    localparam int EV_RI_UP  = 1;
    localparam int EV_TA_UP  = 2;
    localparam int EV_REQ_DN = 3;
    localparam int EV_RI_DN  = 4;
    localparam int EV_TA_DN  = 5;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic pen_i = 1'b0;
    logic ack_m = 1'b0, ack_inj = 1'b0;
    logic ai_m  = 1'b0;
    logic ack_i, ai_i;
    logic req_o, ri_o, ta_o, err_o;
    logic partner_on = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ta_up_cyc = 0;
    int exp_q[$];
    logic [2:0] prev_out = 3'b000;

    assign ack_i = ack_m | ack_inj;
    assign ai_i  = ai_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcport_initiator #(.SYNC_STAGES(SYNC)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .pen_i (pen_i),
        .ack_i (ack_i),
        .ai_i  (ai_i),
        .req_o (req_o),
        .ri_o  (ri_o),
        .ta_o  (ta_o),
        .err_o (err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Partner model: acknowledge follows request after a random delay.
    initial begin
        forever begin
            @(negedge clk);
            if (req_o === 1'b1 && !ack_m && partner_on) begin
                repeat ($urandom_range(1, 5)) @(negedge clk);
                ack_m = 1'b1;
            end else if (req_o === 1'b0 && ack_m) begin
                repeat ($urandom_range(1, 5)) @(negedge clk);
                ack_m = 1'b0;
            end
        end
    end

    // Clock-generator model: grant follows pause request after a random delay.
    initial begin
        forever begin
            @(negedge clk);
            if (ri_o === 1'b1 && !ai_m) begin
                repeat ($urandom_range(1, 5)) @(negedge clk);
                ai_m = 1'b1;
            end else if (ri_o === 1'b0 && ai_m) begin
                repeat ($urandom_range(1, 5)) @(negedge clk);
                ai_m = 1'b0;
            end
        end
    end

    // Monitor: pop one expected event per observed output change.
    always @(negedge clk) begin
        logic [2:0] cur;
        cyc++;
        cur = {req_o, ri_o, ta_o};
        if (cur !== prev_out) begin
            check($countones(cur ^ prev_out) == 1, "R7", "outputs changed at once",
                  $countones(cur ^ prev_out), 1);
            for (int b = 2; b >= 0; b--) begin
                if (cur[b] !== prev_out[b]) begin
                    int ev;
                    int want;
                    case (b)
                        2: ev = cur[b] ? EV_REQ_UP : EV_REQ_DN;
                        1: ev = cur[b] ? EV_RI_UP  : EV_RI_DN;
                        default: ev = cur[b] ? EV_TA_UP : EV_TA_DN;
                    endcase
                    want = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                    check(ev == want, "R5", "event order", ev, want);
                    if (ev == EV_RI_UP) check(ack_i == 1'b1, "R3", "ack at pause request", ack_i, 1);
                    if (ev == EV_TA_UP) begin
                        check(ai_i == 1'b1, "R4", "grant at done", ai_i, 1);
                        ta_up_cyc = cyc;
                    end
                    if (ev == EV_REQ_DN && rst_n)
                        check(cyc - ta_up_cyc == 1, "R4", "req fall delay", cyc - ta_up_cyc, 1);
                    if (ev == EV_RI_DN) check(ack_i == 1'b0, "R5", "ack at pause release", ack_i, 0);
                    if (ev == EV_TA_DN) check(pen_i == 1'b0, "R6", "pen at done fall", pen_i, 0);
                end
            end
        end
        prev_out = cur;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Island driver: one full transfer, holding enable for 'hold' cycles.
    task automatic transfer(input int hold, input bit lat_chk);
        exp_q.push_back(EV_REQ_UP);
        exp_q.push_back(EV_RI_UP);
        exp_q.push_back(EV_TA_UP);
        exp_q.push_back(EV_REQ_DN);
        exp_q.push_back(EV_RI_DN);
        exp_q.push_back(EV_TA_DN);
        @(negedge clk);
        pen_i = 1'b1;
        if (lat_chk) begin
            repeat (SYNC) @(posedge clk);
            @(negedge clk);
            check(req_o == 1'b0, "R9", "req before latency", req_o, 0);
            @(posedge clk);
            @(negedge clk);
            check(req_o == 1'b1, "R9", "req at latency", req_o, 1);
        end
        while (!(ta_o && !ai_i)) @(negedge clk);
        repeat (hold) @(negedge clk);
        check(ta_o == 1'b1, "R6", "done held before pen falls", ta_o, 1);
        pen_i = 1'b0;
        while (ta_o) @(negedge clk);
        check({req_o, ri_o, ta_o} == 3'b000, "R6", "back to idle", {req_o, ri_o, ta_o}, 0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        report();
    end

    initial begin
        do_reset();
        @(negedge clk);
        check({req_o, ri_o, ta_o, err_o} == 4'b0000, "R1", "reset outputs",
              {req_o, ri_o, ta_o, err_o}, 0);

        // Main transfers with random delays and long holds.
        transfer(15, 1'b1);
        for (int i = 0; i < 20; i++) transfer($urandom_range(10, 40), 1'b0);
        check(err_o == 1'b0, "R8", "no error on legal traffic", err_o, 0);

        // Illegal acknowledge in idle.
        @(negedge clk);
        ack_inj = 1'b1;
        repeat (SYNC + 1) @(posedge clk);
        @(negedge clk);
        check(err_o == 1'b1, "R8", "error after illegal ack", err_o, 1);
        ack_inj = 1'b0;
        repeat (10) @(negedge clk);
        check(err_o == 1'b1, "R8", "error sticky", err_o, 1);
        check({req_o, ri_o, ta_o} == 3'b000, "R8", "illegal ack ignored", {req_o, ri_o, ta_o}, 0);
        do_reset();
        @(negedge clk);
        check(err_o == 1'b0, "R1", "reset clears error", err_o, 0);

        // Partner silent: request must stand alone, then enable drops illegally.
        partner_on = 1'b0;
        exp_q.push_back(EV_REQ_UP);
        @(negedge clk);
        pen_i = 1'b1;
        repeat (20) @(negedge clk);
        check(req_o == 1'b1, "R2", "req raised", req_o, 1);
        check({ri_o, ta_o} == 2'b00, "R2", "nothing else without ack", {ri_o, ta_o}, 0);
        pen_i = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        check(err_o == 1'b1, "R8", "error on early enable drop", err_o, 1);
        check(req_o == 1'b1, "R8", "req unchanged by illegal drop", req_o, 1);
        exp_q.push_back(EV_REQ_DN);
        do_reset();
        partner_on = 1'b1;
        @(negedge clk);
        check({req_o, ri_o, ta_o, err_o} == 4'b0000, "R1", "reset from requesting",
              {req_o, ri_o, ta_o, err_o}, 0);

        transfer(25, 1'b1);
        check(exp_q.size() == 0, "R5", "all expected events seen", exp_q.size(), 0);
        report();
    end

endmodule